// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of one pulse-width-modulation channel. It divides the system clock through two prescalers in series. On each divided tick it advances a counter that runs up, down or up-down between zero and a programmable period, or it holds the counter frozen. Each time the counter lands on zero or on the period it raises a one-cycle event strobe. Those strobes, a direction flag and the live count feed a downstream stage that decides when the output pins switch. Software programs the block through a small write/read register port with two registers: a control word and a period. The period can take effect at once, or it can wait in a shadow copy until the counter next lands on zero, so that a period change never cuts a cycle short.

A debug-halt input lets a halted processor freeze the waveform. The control word picks one of three policies. The first stops before the next counter step. The second lets the current cycle run to its natural end and then stops. The third ignores the halt altogether. A three-state machine carries out these policies. In RUN the counter steps freely. A halt under the stop-on-step policy takes RUN straight to HOLD. A halt under the cycle-end policy takes RUN to DRAIN, or directly to HOLD if the same step completes the cycle. DRAIN keeps stepping, and it moves to HOLD when a step lands on the completion point: zero in up and up-down modes, the period in down mode. Both DRAIN and HOLD return to RUN once the effective halt drops. The counter direction is a second two-state machine, UP and DOWN. It flips at the turning points in up-down mode and is forced by the mode in the other two.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction flag reads 1 (up), both event strobes are low, the control word reads 16'h0003 (counter frozen, stop-on-step policy, both prescaler codes 0, shadow loading) and the active period reads 0.
- R2: A write with address 8'h00 sets the control word and a write with address 8'h0A sets the period. A read of 8'h00 returns the control word with bits 13, 6, 5, 4 and 2 as 0, a read of 8'h0A returns the active period, and a read of any other address returns 0. The control fields are: [1:0] mode, [3] immediate-load, [9:7] fast prescaler code, [12:10] slow prescaler code, [15:14] halt policy.
- R3: With control bit 3 at 1, a period write changes the active period on the next cycle. With bit 3 at 0, the write goes only to a shadow copy, and the active period takes the shadow value on the step that lands the counter on 0.
- R4: The counter steps once every F*2^S clock cycles, where S is the slow code and F is 1 for fast code 0 and twice the fast code otherwise.
- R5: Mode 00 (up) adds one per step and wraps to 0 on the step after the count reaches or exceeds the period. The direction flag is 1.
- R6: Mode 01 (down) subtracts one per step and reloads the active period on the step after 0. The direction flag is 0.
- R7: Mode 10 (up-down) counts up to the period, turns and counts down to 0, then turns up again. The direction flag shows the current direction.
- R8: Mode 11 (freeze) holds the counter and the direction and raises no event strobes.
- R9: For exactly one clock after a step, the zero strobe is high if the new count is 0, and the period strobe is high if the new count equals the active period that applied before that step. Both strobes are low in every other cycle.
- R10: With policy 00, the counter takes no step in any cycle that the halt input is high.
- R11: With policy 01, a raised halt lets the counter keep stepping until it lands on 0 (up and up-down modes) or on the period (down mode). The counter then holds until the halt drops.
- R12: With policy 10 or 11, the halt input has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| dbg_halt | input | 1 | Debug halt request |
| cnt_o | output | CNT_W | Live counter value |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |
| zero_evt_o | output | 1 | One-cycle strobe when a step lands on 0 |
| prd_evt_o | output | 1 | One-cycle strobe when a step lands on the period |

## Verification
The bench builds the block with its defaults: a 16-bit counter and an 8-bit address. It programs small periods such as 5, 7 and 0, so that wraps, turnarounds, shadow loads and every halt policy's completion point occur many times within a short run. The fast prescaler codes 0, 3 and 7 and the slow codes 0, 1, 2 and 7 exercise both division stages, including the all-ones slow code that uses the full width of the slow counter.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int CTRL_W = 16;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_UPDN   = 2'b10,
        MODE_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        POL_STEP     = 2'b00,
        POL_CYCLE    = 2'b01,
        POL_FREE_ALT = 2'b10,
        POL_FREE     = 2'b11
    } halt_pol_e;

    typedef enum logic [1:0] {
        HS_RUN   = 2'b00,
        HS_DRAIN = 2'b01,
        HS_HOLD  = 2'b10
    } halt_st_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        halt_pol_e         pol;
        logic [CODE_W-1:0] lo_code;
        logic [CODE_W-1:0] hs_code;
        logic              imm_load;
        cnt_mode_e         mode;
    } ctrl_t;

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale
    import pwm_tb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] hs_code,
    input  logic [CODE_W-1:0] lo_code,
    output logic              tick
);

    // fast stage divides by 1 or 2*code, slow stage by 2**code
    localparam int HS_W = CODE_W + 1;
    localparam int LO_W = (1 << CODE_W) - 1;

    logic [HS_W-1:0] hs_cnt;
    logic [HS_W-1:0] hs_lim;
    logic            hs_tick;
    logic [LO_W-1:0] lo_cnt;
    logic [LO_W-1:0] lo_lim;
    logic            lo_end;

    always_comb begin
        hs_lim  = (hs_code == '0) ? '0 : ({hs_code, 1'b0} - HS_W'(1));
        lo_lim  = (LO_W'(1) << lo_code) - LO_W'(1);
        hs_tick = (hs_cnt >= hs_lim);
        lo_end  = (lo_cnt >= lo_lim);
        tick    = hs_tick && lo_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            if (hs_tick) begin
                hs_cnt <= '0;
                lo_cnt <= lo_end ? '0 : lo_cnt + LO_W'(1);
            end else begin
                hs_cnt <= hs_cnt + HS_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 'h00,
    parameter int PRD_OFS  = 'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              zero_land,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  prd_act
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(PRD_OFS);

    logic [CNT_W-1:0] prd_shd;
    logic             wr_ctrl;
    logic             wr_prd;
    logic             unused_rsv;

    assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
    assign wr_prd     = wr_en && (wr_addr == A_PRD);
    assign unused_rsv = ^{wr_data[13], wr_data[6:4], wr_data[2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{pol: POL_STEP, lo_code: '0, hs_code: '0,
                        imm_load: 1'b0, mode: MODE_FREEZE};
        end else if (wr_ctrl) begin
            ctrl_q <= '{pol:      halt_pol_e'(wr_data[15:14]),
                        lo_code:  wr_data[12:10],
                        hs_code:  wr_data[9:7],
                        imm_load: wr_data[3],
                        mode:     cnt_mode_e'(wr_data[1:0])};
        end
    end

    // shadow always follows writes; active follows writes only in immediate mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_shd <= '0;
            prd_act <= '0;
        end else begin
            if (zero_land && !ctrl_q.imm_load) begin
                prd_act <= prd_shd;
            end
            if (wr_prd) begin
                prd_shd <= wr_data[CNT_W-1:0];
                if (ctrl_q.imm_load) begin
                    prd_act <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        if (rd_addr == A_CTRL) begin
            rd_data = {ctrl_q.pol, 1'b0, ctrl_q.lo_code, ctrl_q.hs_code,
                       3'b000, ctrl_q.imm_load, 1'b0, ctrl_q.mode};
        end else if (rd_addr == A_PRD) begin
            rd_data = CTRL_W'(prd_act);
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/pwm_tb_haltctl.sv
module pwm_tb_haltctl
    import pwm_tb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dbg_halt,
    input  halt_pol_e pol,
    input  cnt_mode_e mode,
    input  logic      tick,
    input  logic      land,
    output logic      step
);

    halt_st_e st_q;
    halt_st_e st_d;
    logic     halt_eff;
    logic     stop_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HS_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // output: step permission
    always_comb begin
        halt_eff = dbg_halt && ((pol == POL_STEP) || (pol == POL_CYCLE));
        stop_now = dbg_halt && (pol == POL_STEP);
        step     = tick && (mode != MODE_FREEZE) && (st_q != HS_HOLD) && !stop_now;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN: begin
                if (stop_now) begin
                    st_d = HS_HOLD;
                end else if (halt_eff) begin
                    st_d = (step && land) ? HS_HOLD : HS_DRAIN;
                end
            end
            HS_DRAIN: begin
                if (!halt_eff) begin
                    st_d = HS_RUN;
                end else if (step && land) begin
                    st_d = HS_HOLD;
                end
            end
            HS_HOLD: begin
                if (!halt_eff) begin
                    st_d = HS_RUN;
                end
            end
            default: st_d = HS_RUN;
        endcase
    end

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_up,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             land,
    output logic             cand_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_e             dir_q;
    dir_e             dir_d;
    logic [CNT_W-1:0] cand;

    always_comb begin
        cand  = cnt_q;
        dir_d = dir_q;
        unique case (mode)
            MODE_UP: begin
                dir_d = DIR_UP;
                cand  = (cnt_q >= prd) ? '0 : cnt_q + ONE;
            end
            MODE_DOWN: begin
                dir_d = DIR_DOWN;
                cand  = (cnt_q == '0) ? prd : cnt_q - ONE;
            end
            MODE_UPDN: begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (cnt_q >= prd) begin
                            dir_d = DIR_DOWN;
                            cand  = (cnt_q == '0) ? '0 : cnt_q - ONE;
                        end else begin
                            cand = cnt_q + ONE;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == '0) begin
                            dir_d = DIR_UP;
                            cand  = (prd == '0) ? '0 : ONE;
                        end else begin
                            cand = cnt_q - ONE;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        cand_zero = (cand == '0);
        land      = (mode == MODE_DOWN) ? (cand == prd) : cand_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_q    <= DIR_UP;
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end else if (step) begin
            cnt_q    <= cand;
            dir_q    <= dir_d;
            zero_evt <= cand_zero;
            prd_evt  <= (cand == prd);
        end else begin
            zero_evt <= 1'b0;
            prd_evt  <= 1'b0;
        end
    end

    assign dir_up = (dir_q == DIR_UP);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 'h00,
    parameter int PRD_OFS  = 'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic              dbg_halt,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_up_o,
    output logic              zero_evt_o,
    output logic              prd_evt_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] prd_act;
    logic             tick;
    logic             step;
    logic             land;
    logic             cand_zero;
    logic             zero_land;

    assign zero_land = step && cand_zero;

    pwm_tb_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .PRD_OFS(PRD_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .zero_land(zero_land), .ctrl_q(ctrl_q), .prd_act(prd_act)
    );

    pwm_tb_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .hs_code(ctrl_q.hs_code),
        .lo_code(ctrl_q.lo_code), .tick(tick)
    );

    pwm_tb_haltctl u_halt (
        .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .pol(ctrl_q.pol),
        .mode(ctrl_q.mode), .tick(tick), .land(land), .step(step)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .mode(ctrl_q.mode),
        .prd(prd_act), .cnt_q(cnt_o), .dir_up(dir_up_o),
        .zero_evt(zero_evt_o), .prd_evt(prd_evt_o), .land(land),
        .cand_zero(cand_zero)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbg_halt,
    input logic [1:0]       mode,
    input logic [1:0]       pol,
    input logic [CNT_W-1:0] cnt,
    input logic             zero_evt
);

    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

    // R6
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1) || $past(cnt) == '0));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> $stable(cnt));

    // R9
    zero_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (cnt == '0));

    // R10
    halt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && pol == 2'b00) |=> $stable(cnt));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .mode(ctrl_q.mode),
    .pol(ctrl_q.pol), .cnt(cnt_o), .zero_evt(zero_evt_o)
);

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic [15:0] cnt_o;
    logic        dir_up_o;
    logic        zero_evt_o;
    logic        prd_evt_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    done = 0;

    // reference state
    int m_ctrl = 3, m_sh = 0, m_act = 0, m_hs = 0, m_lo = 0;
    int m_cnt = 0, m_dir = 1, m_z = 0, m_p = 0, m_st = 0;

    always #5 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .cnt_o(cnt_o), .dir_up_o(dir_up_o),
        .zero_evt_o(zero_evt_o), .prd_evt_o(prd_evt_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 3; m_sh = 0; m_act = 0; m_hs = 0; m_lo = 0;
            m_cnt = 0; m_dir = 1; m_z = 0; m_p = 0; m_st = 0;
        end else begin
            int mode, imm, hsc, loc, pol, hdiv, lolim, cand, cdir, nst;
            bit htick, tick, step, land, heff, snow;
            mode = m_ctrl & 3;
            imm = (m_ctrl >> 3) & 1;
            hsc = (m_ctrl >> 7) & 7;
            loc = (m_ctrl >> 10) & 7;
            pol = (m_ctrl >> 14) & 3;
            hdiv = (hsc == 0) ? 1 : 2 * hsc;
            lolim = (1 << loc) - 1;
            htick = (m_hs >= hdiv - 1);
            tick = htick && (m_lo >= lolim);
            if (htick) begin
                m_hs = 0;
                m_lo = (m_lo >= lolim) ? 0 : m_lo + 1;
            end else m_hs = m_hs + 1;
            snow = dbg_halt && pol == 0;
            heff = dbg_halt && pol < 2;
            step = tick && mode != 3 && m_st != 2 && !snow;
            cand = m_cnt; cdir = m_dir;
            if (mode == 0) begin cdir = 1; cand = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
            else if (mode == 1) begin cdir = 0; cand = (m_cnt == 0) ? m_act : m_cnt - 1; end
            else if (mode == 2) begin
                if (m_dir == 1) begin
                    if (m_cnt >= m_act) begin cdir = 0; cand = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else cand = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin cdir = 1; cand = (m_act == 0) ? 0 : 1; end
                    else cand = m_cnt - 1;
                end
            end
            land = (mode == 1) ? (cand == m_act) : (cand == 0);
            nst = m_st;
            if (m_st == 0) begin
                if (snow) nst = 2;
                else if (heff) nst = (step && land) ? 2 : 1;
            end else if (m_st == 1) begin
                if (!heff) nst = 0;
                else if (step && land) nst = 2;
            end else if (!heff) nst = 0;
            m_st = nst;
            m_z = step && cand == 0;
            m_p = step && cand == m_act;
            if (step && cand == 0 && imm == 0) m_act = m_sh;
            if (step) begin m_cnt = cand; m_dir = cdir; end
            if (wr_en && wr_addr == 8'h00) m_ctrl = int'(wr_data) & 'hDF8B;
            if (wr_en && wr_addr == 8'h0A) begin
                m_sh = int'(wr_data);
                if (imm == 1) m_act = int'(wr_data);
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #4;
        if (!done) begin
            int erd;
            erd = (rd_addr == 8'h00) ? m_ctrl : (rd_addr == 8'h0A) ? m_act : 0;
            chk(phase, "cnt", int'(cnt_o), m_cnt);
            chk((phase == "R1") ? "R1" : "R7", "dir", int'(dir_up_o), m_dir);
            chk("R9", "zero_evt", int'(zero_evt_o), m_z);
            chk("R9", "prd_evt", int'(prd_evt_o), m_p);
            chk("R2", "rd_data", int'(rd_data), erd);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R1: reset state
        phase = "R1";
        run(4);
        rst_n = 1'b1;
        run(3);
        rd_addr = 8'h0A;
        run(2);
        // R3: immediate period load while frozen
        phase = "R3";
        wr(8'h00, 16'h000B);
        wr(8'h0A, 16'd5);
        run(3);
        // R5: up mode, no division
        phase = "R5";
        rd_addr = 8'h00;
        wr(8'h00, 16'h0008);
        run(20);
        // R4: prescaler combinations
        phase = "R4";
        wr(8'h00, 16'h0988);
        run(200);
        wr(8'h00, 16'h0408);
        run(30);
        wr(8'h00, 16'h0388);
        run(100);
        // R6: down mode
        phase = "R6";
        wr(8'h00, 16'h0009);
        run(20);
        // R7: up-down mode
        phase = "R7";
        wr(8'h00, 16'h000A);
        run(30);
        // R5: zero period boundary
        phase = "R5";
        wr(8'h0A, 16'd0);
        run(6);
        wr(8'h0A, 16'd5);
        run(8);
        // R3: shadow loading in up and down modes
        phase = "R3";
        rd_addr = 8'h0A;
        wr(8'h00, 16'h0000);
        run(2);
        wr(8'h0A, 16'd9);
        run(30);
        wr(8'h00, 16'h0001);
        wr(8'h0A, 16'd4);
        run(30);
        // R8: freeze
        phase = "R8";
        wr(8'h00, 16'h0003);
        run(12);
        // R10: halt stops before next step
        phase = "R10";
        wr(8'h00, 16'h0008);
        wr(8'h0A, 16'd7);
        run(3);
        dbg_halt = 1'b1;
        run(12);
        dbg_halt = 1'b0;
        run(5);
        // R11: halt waits for cycle end in each mode
        phase = "R11";
        wr(8'h00, 16'h4008);
        run(3);
        dbg_halt = 1'b1;
        run(20);
        dbg_halt = 1'b0;
        run(4);
        wr(8'h00, 16'h4009);
        run(3);
        dbg_halt = 1'b1;
        run(20);
        dbg_halt = 1'b0;
        run(4);
        wr(8'h00, 16'h400A);
        run(5);
        dbg_halt = 1'b1;
        run(25);
        dbg_halt = 1'b0;
        run(6);
        // R12: free-run ignores halt
        phase = "R12";
        wr(8'h00, 16'hC008);
        dbg_halt = 1'b1;
        run(20);
        wr(8'h00, 16'h8009);
        run(12);
        dbg_halt = 1'b0;
        // R2: reserved bits, unmapped address, largest codes
        phase = "R2";
        rd_addr = 8'h00;
        wr(8'h00, 16'hFFF4);
        run(4);
        rd_addr = 8'h04;
        run(4);
        run(1800);
        summary();
    end

endmodule